// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is a read-only bit-serial store. A configuration controller reads a bitstream from it by pulsing a serial clock. The contents come from a parameter vector. An internal pointer selects the bit that is presented. Each rising edge of the serial clock moves the pointer on by one. The serial clock is sampled in the system clock domain and its rising edges are detected there, so every output is a register on the system clock.

One pin serves as both reset and output enable. A parameter selects its polarity. In the reset level the pin rewinds the pointer. In the opposite level it lets the memory drive its data. An active-low chip enable gates the memory. When the last stored bit has been consumed, a chip-enable-out goes low and the data driver turns off.

Wiring the chip-enable-out of one memory to the chip enable of the next chains them into one uninterrupted stream. The high-impedance state is brought out as a drive-enable output beside the data bit, and the board or the next level up resolves the shared line from it.

Top module: `cfg_serial_rom`

## Requirements
- R1: While `rst` is high, and in the first cycles after it, the pointer is at bit 0, `dout_en` is 0 and `ceo_n` is 1. Once enabled, the memory presents `INIT[0]`.
- R2: With `POL = RST_LOW_OE_HIGH`, `rst_oe` low is reset and `rst_oe` high enables output. With `POL = RST_HIGH_OE_LOW`, `rst_oe` high is reset and `rst_oe` low enables output.
- R3: Holding `rst_oe` at its reset level forces `dout_en` to 0 and `ceo_n` to 1, and returns the pointer to bit 0. After release, `INIT[0]` is presented again.
- R4: While `ce_n` is 1, `dout_en` is 0 and serial clock edges do not move the pointer.
- R5: Bit index 0 (the LSB of `INIT`) goes out first. After k serial clock rising edges with the memory enabled, `dout` shows `INIT[k]`, with `dout_en` 1.
- R6: After `DEPTH` rising edges, `ceo_n` is 0 and `dout_en` is 0. Further edges change nothing. `ceo_n` low never coincides with `dout_en` high.
- R7: `ceo_n` stays 1 while fewer than `DEPTH` bits have been consumed.
- R8: Two memories, the second with its `ce_n` driven by the first one's `ceo_n`, deliver both contents back to back. Exactly one of them drives at each bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial clock from the reader. Each rising edge consumes one bit |
| rst_oe | input | 1 | Combined reset / output-enable pin, polarity set by `POL` |
| ce_n | input | 1 | Active-low chip enable |
| dout | output | 1 | Current data bit |
| dout_en | output | 1 | Data drive enable. 0 means the data line is high-impedance |
| ceo_n | output | 1 | Active-low chip-enable-out, low once all bits are consumed |

## Verification
The bench builds three 12-bit memories. Two use the default polarity and are chained through their chip-enable handoff. The third uses the inverted polarity and stands alone. Because the depth is small, every bit position of the chained 24-bit stream is compared against the parameter vectors. That walk crosses the handoff boundary and runs past the end. Both polarity decodes of the reset/output-enable pin are exercised, along with rewinding mid-stream and ignoring clock edges while disabled.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  typedef enum logic {
    RST_LOW_OE_HIGH = 1'b0,
    RST_HIGH_OE_LOW = 1'b1
  } rstoe_pol_e;

  function automatic int ptr_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int idx_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/cfgrom_clk_edge.sv
module cfgrom_clk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], sclk};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R5
  sclk_rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cfgrom_pointer.sv
module cfgrom_pointer #(
  parameter int DEPTH = 64,
  localparam int AW = cfgrom_pkg::ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          exhausted
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH);

  assign exhausted = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)              ptr <= '0;
    else if (step && !exhausted) ptr <= ptr + 1'b1;
  end

  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0));

  // R3
  ptr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ptr == '0);
endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array #(
  parameter int DEPTH = 64,
  parameter logic [DEPTH-1:0] INIT = '0,
  localparam int AW = cfgrom_pkg::ptr_width(DEPTH),
  localparam int IW = cfgrom_pkg::idx_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic          rd_bit
);
  logic mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem[i] = INIT[i];
  end

  logic          in_range;
  logic [IW-1:0] idx;

  assign in_range = (addr < AW'(DEPTH));
  assign idx      = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst)           rd_bit <= 1'b0;
    else if (in_range) rd_bit <= mem[idx];
    else               rd_bit <= 1'b0;
  end
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter logic [DEPTH-1:0] INIT = '0,
  parameter rstoe_pol_e POL = RST_LOW_OE_HIGH,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic rst_oe,
  input  logic ce_n,
  output logic dout,
  output logic dout_en,
  output logic ceo_n
);
  localparam int AW = ptr_width(DEPTH);

  logic          pin_rst;
  logic          rise;
  logic [AW-1:0] ptr;
  logic          exhausted;
  logic          rd_bit;
  logic          en_q;
  logic          ceo_q;

  if (POL == RST_HIGH_OE_LOW) begin : g_pol_hi
    assign pin_rst = rst_oe;
  end else begin : g_pol_lo
    assign pin_rst = ~rst_oe;
  end

  cfgrom_clk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise)
  );

  cfgrom_pointer #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .clr       (pin_rst),
    .step      (rise & ~ce_n),
    .ptr       (ptr),
    .exhausted (exhausted)
  );

  cfgrom_array #(.DEPTH(DEPTH), .INIT(INIT)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .addr   (ptr),
    .rd_bit (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ceo_q <= 1'b1;
    end else begin
      en_q  <= ~ce_n & ~pin_rst & ~exhausted;
      ceo_q <= ~exhausted;
    end
  end

  assign dout    = rd_bit;
  assign dout_en = en_q;
  assign ceo_n   = ceo_q;

  // R1
  por_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ceo_n && !dout_en));

  // R6
  handoff_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> !dout_en);

  // R4
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !pin_rst) |=> $stable(ptr));

  // R2
  pin_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pin_rst |=> !dout_en);
endmodule

// File: tb/sim_cfg_serial_rom.sv
module sim_cfg_serial_rom;
  import cfgrom_pkg::*;

  localparam int D = 12;
  localparam logic [D-1:0] IA = 12'b1011_0010_1101;
  localparam logic [D-1:0] IB = 12'b0110_1001_1100;
  localparam logic [D-1:0] IC = 12'b1100_0101_0011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic pin_ab = 1'b1;
  logic ce_a = 1'b0;
  logic pin_c = 1'b0;
  logic ce_c = 1'b1;
  logic d_a, en_a, ceo_a, d_b, en_b, ceo_b, d_c, en_c, ceo_c;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  cfg_serial_rom #(.DEPTH(D), .INIT(IA), .POL(RST_LOW_OE_HIGH)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .rst_oe(pin_ab), .ce_n(ce_a),
    .dout(d_a), .dout_en(en_a), .ceo_n(ceo_a));

  cfg_serial_rom #(.DEPTH(D), .INIT(IB), .POL(RST_LOW_OE_HIGH)) u1 (
    .clk(clk), .rst(rst), .sclk(sclk), .rst_oe(pin_ab), .ce_n(ceo_a),
    .dout(d_b), .dout_en(en_b), .ceo_n(ceo_b));

  cfg_serial_rom #(.DEPTH(D), .INIT(IC), .POL(RST_HIGH_OE_LOW)) u2 (
    .clk(clk), .rst(rst), .sclk(sclk), .rst_oe(pin_c), .ce_n(ce_c),
    .dout(d_c), .dout_en(en_c), .ceo_n(ceo_c));

  logic bus;
  assign bus = en_a ? d_a : (en_b ? d_b : 1'bz);

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  function automatic logic stream_bit(input int k);
    return (k < D) ? IA[k] : IB[k-D];
  endfunction

  initial begin
    tick(4);
    chk("R1 en_a in reset", en_a, 1'b0);
    chk("R1 ceo_a in reset", ceo_a, 1'b1);
    chk("R1 en_c in reset", en_c, 1'b0);
    rst = 1'b0;
    tick(4);
    chk("R1 first bit driven", en_a, 1'b1);
    chk("R1 first bit value", bus, IA[0]);
    chk("R8 downstream idle", en_b, 1'b0);

    for (int k = 0; k < 2*D; k++) begin
      chk("R5/R8 stream bit", bus, stream_bit(k));
      chk("R8 single driver", en_a & en_b, 1'b0);
      chk("R7/R6 ceo_a", ceo_a, (k < D) ? 1'b1 : 1'b0);
      chk("R7 ceo_b", ceo_b, 1'b1);
      pulse();
    end
    chk("R6 a off at end", en_a, 1'b0);
    chk("R6 b off at end", en_b, 1'b0);
    chk("R6 ceo_b low", ceo_b, 1'b0);
    pulse();
    chk("R6 extra edge en_b", en_b, 1'b0);
    chk("R6 extra edge ceo_b", ceo_b, 1'b0);

    pin_ab = 1'b0;
    tick(4);
    chk("R3 ceo_a rearmed", ceo_a, 1'b1);
    chk("R3 en_a off", en_a, 1'b0);
    chk("R3 ceo_b rearmed", ceo_b, 1'b1);
    pulse();
    chk("R2 low pin holds reset", en_a, 1'b0);
    pin_ab = 1'b1;
    tick(4);
    chk("R3 rewound bit0", bus, IA[0]);
    pulse(); pulse();
    chk("R5 bit2 after rewind", bus, IA[2]);

    ce_a = 1'b1;
    tick(4);
    chk("R4 ce high no drive", en_a, 1'b0);
    pulse(); pulse(); pulse();
    chk("R4 still undriven", en_a, 1'b0);
    ce_a = 1'b0;
    tick(4);
    chk("R4 pointer held", bus, IA[2]);

    ce_c = 1'b0;
    tick(4);
    chk("R2 inverted pin low enables", en_c, 1'b1);
    chk("R2 inverted bit0", d_c, IC[0]);
    pulse(); pulse(); pulse();
    chk("R5 inverted bit3", d_c, IC[3]);
    pin_c = 1'b1;
    tick(4);
    chk("R2 inverted pin high disables", en_c, 1'b0);
    pin_c = 1'b0;
    tick(4);
    chk("R3 inverted rewind", d_c, IC[0]);
    chk("R7 ceo_c high", ceo_c, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule